// File: doc/BRIEF.md
# Multi-drop Device Session Controller

This block keeps the session state of one authentication slave that shares a half-duplex single-wire bus with other slaves. A bit-level front end decodes the line and presents single-cycle pulses for a wake token and for the transmit, command, sleep and pause flags. A pause flag may come with a 4-bit address field. From these pulses the controller moves between four states: sleep, awake, busy and paused. It also decides when the front end must send a wake acknowledge, an error code or the computed result.

A host addresses one device by pausing all the others with address-qualified pause flags. It then runs a computation on the one device still active. Every device runs a watchdog that starts on wake. Bus traffic cannot restart it. When it runs out, the device goes back to sleep from any state, so that the next wake token brings the whole bus back together. The cryptographic engine is outside the block and is seen only through a busy level and a done pulse.

Top module: `sess_ctrl`

## Requirements
- R1: After reset the state code is 0 (sleep) and `rsp_req` is low.
- R2: In sleep only `tok_wake` has an effect. The transmit, command, sleep and pause flags give no response and leave the state at 0. A wake token moves the state to 1 (awake) on the next cycle.
- R3: The first transmit flag after a wake requests a response of type 1 (wake acknowledge). Later transmit flags never request it again until the next wake.
- R4: A command flag with `cmd_fmt_err` low moves the state to 2 (busy). A transmit flag while the state is busy, or while `eng_busy` is high, requests no response.
- R5: A command flag with `cmd_fmt_err` high keeps the state at 1. Every later transmit flag requests response type 2 (error) until the next command.
- R6: `eng_done` in busy returns the state to 1. From then on every transmit flag requests response type 3 (result), including repeated ones, until the next command or sleep.
- R7: A pause flag in awake moves the state to 3 (paused) when `pause_addr_vld` is low, or when `pause_addr` equals `dev_addr`. On a mismatch the state stays 1 and the device keeps answering transmit flags.
- R8: In paused, every flag and the wake token are ignored: no response is requested and the state stays 3.
- R9: A sleep flag in awake moves the state to 0.
- R10: Exactly `WDT_CYCLES` clock edges after the edge that accepts a wake, the state becomes 0, whatever the state is and whatever bus traffic came in between.
- R11: `rsp_req` is a single-cycle pulse. It appears in the cycle after the transmit flag that causes it, with `rsp_type` valid in that cycle. `rsp_type` is 0 whenever `rsp_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_wake | input | 1 | Wake token pulse |
| flg_xmit | input | 1 | Transmit flag pulse |
| flg_cmd | input | 1 | Command flag pulse; a complete command block has been received |
| cmd_fmt_err | input | 1 | Qualifies `flg_cmd`: the command block has a format error |
| flg_sleep | input | 1 | Sleep flag pulse |
| flg_pause | input | 1 | Pause flag pulse |
| pause_addr_vld | input | 1 | The pause flag carries an address field |
| pause_addr | input | 4 | Address field of the pause flag |
| dev_addr | input | 4 | This device's address |
| eng_busy | input | 1 | Engine is computing |
| eng_done | input | 1 | Engine finished; result available |
| rsp_req | output | 1 | Response request strobe to the front end |
| rsp_type | output | 2 | 0 none, 1 wake acknowledge, 2 error, 3 result |
| state_o | output | 2 | 0 sleep, 1 awake, 2 busy, 3 paused |

## Verification
The hardest case to reach is a watchdog expiry that lands while the device is paused or busy. In those states the ports show nothing, so the expiry can only be seen on the state code. The stimulus first parks the device with a matching pause flag. It then sends transmit, command, sleep and wake pulses that must all be ignored, and counts clock edges from the wake until the state code drops to sleep. The count must equal the watchdog length exactly. The bench then wakes the device again and checks that the wake acknowledge comes back.

// File: rtl/sess_pkg.sv
package sess_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_AWAKE = 2'd1,
        ST_BUSY  = 2'd2,
        ST_PAUSE = 2'd3
    } sess_state_e;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_WAKE   = 2'd1,
        RSP_ERROR  = 2'd2,
        RSP_RESULT = 2'd3
    } sess_rsp_e;

    typedef struct packed {
        sess_state_e st;
        logic        ack_pend;
        logic        err;
        logic        res;
        logic        rsp_req;
        sess_rsp_e   rsp;
    } sess_regs_t;
endpackage

// File: rtl/sess_wdt.sv
module sess_wdt #(
    parameter int unsigned WDT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(WDT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = '0;
        else if (run && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
        else if (!run)
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == LAST);

    // R10
    wdt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/sess_addr_match.sv
module sess_addr_match #(
    parameter int unsigned AW = 4
) (
    input  logic [AW-1:0] field,
    input  logic          field_vld,
    input  logic [AW-1:0] own,
    output logic          hit
);
    assign hit = !field_vld || (field == own);
endmodule

// File: rtl/sess_ctrl.sv
module sess_ctrl
    import sess_pkg::*;
#(
    parameter int unsigned WDT_CYCLES = 64,
    parameter int unsigned AW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_wake,
    input  logic          flg_xmit,
    input  logic          flg_cmd,
    input  logic          cmd_fmt_err,
    input  logic          flg_sleep,
    input  logic          flg_pause,
    input  logic          pause_addr_vld,
    input  logic [AW-1:0] pause_addr,
    input  logic [AW-1:0] dev_addr,
    input  logic          eng_busy,
    input  logic          eng_done,
    output logic          rsp_req,
    output logic [1:0]    rsp_type,
    output logic [1:0]    state_o
);
    sess_regs_t r_d, r_q;
    logic wake_ok, wdt_run, wdt_exp, addr_hit;

    assign wake_ok = (r_q.st == ST_SLEEP) && tok_wake;
    assign wdt_run = (r_q.st != ST_SLEEP);

    sess_wdt #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_ok),
        .run   (wdt_run),
        .expire(wdt_exp)
    );

    sess_addr_match #(.AW(AW)) u_match (
        .field    (pause_addr),
        .field_vld(pause_addr_vld),
        .own      (dev_addr),
        .hit      (addr_hit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rsp_req = 1'b0;
        r_d.rsp     = RSP_NONE;
        unique case (r_q.st)
            ST_SLEEP: begin
                if (tok_wake) begin
                    r_d.st       = ST_AWAKE;
                    r_d.ack_pend = 1'b1;
                    r_d.err      = 1'b0;
                    r_d.res      = 1'b0;
                end
            end
            ST_AWAKE: begin
                if (flg_sleep) begin
                    r_d.st = ST_SLEEP;
                end else if (flg_cmd) begin
                    r_d.ack_pend = 1'b0;
                    r_d.res      = 1'b0;
                    r_d.err      = cmd_fmt_err;
                    if (!cmd_fmt_err) r_d.st = ST_BUSY;
                end else if (flg_pause && addr_hit) begin
                    r_d.st = ST_PAUSE;
                end else if (flg_xmit && !eng_busy) begin
                    if (r_q.ack_pend) begin
                        r_d.rsp_req  = 1'b1;
                        r_d.rsp      = RSP_WAKE;
                        r_d.ack_pend = 1'b0;
                    end else if (r_q.err) begin
                        r_d.rsp_req = 1'b1;
                        r_d.rsp     = RSP_ERROR;
                    end else if (r_q.res) begin
                        r_d.rsp_req = 1'b1;
                        r_d.rsp     = RSP_RESULT;
                    end
                end
            end
            ST_BUSY: begin
                if (eng_done) begin
                    r_d.st  = ST_AWAKE;
                    r_d.res = 1'b1;
                end
            end
            default: begin
            end
        endcase
        if (wdt_exp) begin
            r_d.st      = ST_SLEEP;
            r_d.rsp_req = 1'b0;
            r_d.rsp     = RSP_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_SLEEP, ack_pend: 1'b0, err: 1'b0, res: 1'b0,
                             rsp_req: 1'b0, rsp: RSP_NONE};
        else        r_q <= r_d;
    end

    assign rsp_req  = r_q.rsp_req;
    assign rsp_type = r_q.rsp;
    assign state_o  = r_q.st;

    // R2
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && !tok_wake) |=> (r_q.st == ST_SLEEP));
    // R2
    sleep_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP) |=> !rsp_req);
    // R8
    pause_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PAUSE) |=> !rsp_req);
    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && flg_xmit) |=> !rsp_req);
    // R10
    wdt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_exp |=> (r_q.st == ST_SLEEP));
    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_req |=> !rsp_req);
    // R11
    rsp_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_req |-> (rsp_type == 2'd0));
endmodule

// File: tb/sim_sess_ctrl.sv
module sim_sess_ctrl;
    localparam int W = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_wake = 0, flg_xmit = 0, flg_cmd = 0, cmd_fmt_err = 0;
    logic flg_sleep = 0, flg_pause = 0, pause_addr_vld = 0;
    logic [3:0] pause_addr = 4'd0, dev_addr = 4'd5;
    logic eng_busy = 0, eng_done = 0;
    logic rsp_req;
    logic [1:0] rsp_type, state_o;

    int checks = 0, fails = 0, cyc = 0, cyc_wake = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sess_ctrl #(.WDT_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_wake(tok_wake), .flg_xmit(flg_xmit),
        .flg_cmd(flg_cmd), .cmd_fmt_err(cmd_fmt_err), .flg_sleep(flg_sleep),
        .flg_pause(flg_pause), .pause_addr_vld(pause_addr_vld),
        .pause_addr(pause_addr), .dev_addr(dev_addr), .eng_busy(eng_busy),
        .eng_done(eng_done), .rsp_req(rsp_req), .rsp_type(rsp_type),
        .state_o(state_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // response after one flag: {rsp_req, rsp_type}
    function automatic int rsp();
        return rsp_req ? (4 + int'(rsp_type)) : int'(rsp_type);
    endfunction

    task automatic pulse(ref logic f);
        @(negedge clk) f = 1'b1;
        @(negedge clk) f = 1'b0;
    endtask

    task automatic wake();
        pulse(tok_wake);
        cyc_wake = cyc;
    endtask

    task automatic go_sleep();
        if (state_o == 2'd1) pulse(flg_sleep);
        for (int i = 0; i < 4 * W && state_o != 2'd0; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 state", state_o, 0);
        chk("R1 rsp_req", rsp_req, 0);
    endtask

    task automatic t_sleep_ignore();
        pulse(flg_xmit);  chk("R2 xmit in sleep", rsp(), 0);
        pulse(flg_cmd);   chk("R2 cmd in sleep", state_o, 0);
        pulse(flg_pause); chk("R2 pause in sleep", state_o, 0);
        wake();           chk("R2 wake", state_o, 1);
    endtask

    task automatic t_wake_ack();
        pulse(flg_xmit); chk("R3 wake ack", rsp(), 5);
        @(negedge clk);  chk("R11 single pulse", rsp(), 0);
        pulse(flg_xmit); chk("R3 ack once", rsp(), 0);
        pulse(flg_sleep); chk("R9 sleep flag", state_o, 0);
    endtask

    task automatic t_cmd_ok();
        wake(); pulse(flg_xmit);
        cmd_fmt_err = 0; pulse(flg_cmd); chk("R4 busy", state_o, 2);
        pulse(flg_xmit); chk("R4 xmit while busy", rsp(), 0);
        pulse(eng_done); chk("R6 done", state_o, 1);
        eng_busy = 1; pulse(flg_xmit); chk("R4 eng_busy ignore", rsp(), 0);
        eng_busy = 0;
        pulse(flg_xmit); chk("R6 result", rsp(), 7);
        pulse(flg_xmit); chk("R6 result repeat", rsp(), 7);
        go_sleep();
    endtask

    task automatic t_cmd_err();
        wake();
        cmd_fmt_err = 1; pulse(flg_cmd); cmd_fmt_err = 0;
        chk("R5 stays awake", state_o, 1);
        pulse(flg_xmit); chk("R5 error", rsp(), 6);
        pulse(flg_xmit); chk("R5 error repeat", rsp(), 6);
        go_sleep();
    endtask

    task automatic t_pause_mismatch();
        wake();
        pause_addr_vld = 1; pause_addr = 4'd9; pulse(flg_pause);
        chk("R7 mismatch stays", state_o, 1);
        pulse(flg_xmit); chk("R7 still answers", rsp(), 5);
        pause_addr_vld = 0; pulse(flg_pause);
        chk("R7 no address pauses", state_o, 3);
        go_sleep();
    endtask

    task automatic t_pause_wdt();
        wake();
        pause_addr_vld = 1; pause_addr = 4'd5; pulse(flg_pause);
        pause_addr_vld = 0;
        chk("R7 match pauses", state_o, 3);
        pulse(flg_xmit);  chk("R8 xmit ignored", rsp(), 0);
        pulse(flg_cmd);   chk("R8 cmd ignored", state_o, 3);
        pulse(flg_sleep); chk("R8 sleep ignored", state_o, 3);
        pulse(tok_wake);  chk("R8 wake ignored", state_o, 3);
        for (int i = 0; i < 4 * W && state_o != 2'd0; i++) @(negedge clk);
        chk("R10 expiry cycles", cyc - cyc_wake, W);
        wake(); pulse(flg_xmit); chk("R10 rewake ack", rsp(), 5);
        for (int i = 0; i < 4 * W && state_o != 2'd0; i++) @(negedge clk);
        chk("R10 expiry from awake", cyc - cyc_wake, W);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sleep_ignore();
        t_wake_ack();
        t_cmd_ok();
        t_cmd_err();
        t_pause_mismatch();
        t_pause_wdt();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule